// File: doc/BRIEF.md
# Gigabit Ethernet Byte-Stream Rate Matcher

This block moves an 8b/10b-decoded byte stream from the recovered receive clock into the local clock domain of a 1000BASE-X receiver. Every byte travels with its control flag through a 32-entry dual-clock buffer. Pointers cross between the two domains as Gray codes through two-flop synchronizers. The buffer absorbs the frequency difference between the far-end transmitter and the local reference, which can reach ±100 ppm at each end and 200 ppm in total.

To stop the buffer from overflowing or running dry, the read side compensates on recognised two-byte units. In inter-packet gaps the unit is the idle set made of a comma followed by D16.2. During auto-negotiation it is the comma and D2.2 that open a configuration set. The two configuration bytes that follow are never touched. A unit is dropped when the buffer is more than three quarters full, and sent twice when it is less than one quarter full. The block does nothing until the word aligner reports synchronization. When synchronization is lost, the buffer is flushed.

Top module: `gbe_rate_matcher`

## Requirements
- R1: Away from compensation, every byte written while synchronized comes out on the read side in the same order, with its control flag unchanged.
- R2: While the synchronization input is low, nothing is written, nothing is output and no unit is inserted or deleted. A falling synchronization input flushes the buffer. After it rises again, output starts only once the fill level has reached half the depth, and it carries only bytes written after the rise.
- R3: A candidate unit is a comma byte (value 0xBC with the control flag 1) followed by a byte with the control flag 0 and value 0x50 (D16.2) or 0x42 (D2.2). Byte positions count from 0 at the first byte written after synchronization rises. The comma must sit on an even position.
- R4: When the read-side fill level exceeds 24 and a candidate unit is at the head, both of its bytes are removed. In that read cycle `rd_deleted` is high for one cycle and `rd_valid` is low.
- R5: When the read-side fill level is below 8 and a candidate unit is at the head, the unit is output twice. `rd_inserted` is high for one cycle, together with the first copy of the comma byte.
- R6: Configuration sets are compensated only through their leading comma and D2.2 pair, and their two data bytes are always delivered. Idle sets whose second byte is D5.6 (0xC5) are never compensated.
- R7: At most one two-byte unit is inserted or deleted for each candidate set in the stream.
- R8: A comma that sits on an odd byte position is never inserted or deleted, even when the byte after it is 0x50 or 0x42.
- R9: `wr_full` is high while the write-side fill level equals the depth, and writes are dropped during that time. `rd_empty` is high in the cycle after the read-side fill level is zero, and `rd_valid` is low whenever `rd_empty` is high.
- R10: After reset, `rd_valid`, `rd_inserted`, `rd_deleted` and `wr_full` are low and `rd_empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_byte | input | 8 | Decoded byte, written on every wr_clk edge while synchronized |
| wr_is_k | input | 1 | Control flag of wr_byte |
| wr_sync_ok | input | 1 | Synchronization status from the word aligner |
| wr_full | output | 1 | Buffer full, write domain |
| rd_clk | input | 1 | Local reference clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_byte | output | 8 | Output byte |
| rd_is_k | output | 1 | Control flag of rd_byte |
| rd_valid | output | 1 | rd_byte carries a byte this cycle |
| rd_inserted | output | 1 | One-cycle pulse on the first byte of a repeated unit |
| rd_deleted | output | 1 | One-cycle pulse when a unit is dropped |
| rd_empty | output | 1 | Buffer empty, read domain |

## Verification
The bench keeps the write clock within 2.5 % of the read clock, first faster and then slower, so that the fill level crosses both marks. The streams mix frames, D5.6 idles, D16.2 idles, configuration sets and a decoy comma on an odd position. A scoreboard accepts a deletion or insertion only when the head of its expected queue is a legal candidate, so it can tell a correct compensation from one on the wrong code, the wrong parity or a repeated unit. Streams of data bytes only then drain the buffer to empty and fill it to full. A final sequence drops synchronization and raises it again, which shows that the flush discards the old bytes.

// File: rtl/gbe_rm_pkg.sv
package gbe_rm_pkg;

  localparam logic [7:0] SYM_COMMA = 8'hBC;  // K28.5
  localparam logic [7:0] SYM_IDLE2 = 8'h50;  // D16.2
  localparam logic [7:0] SYM_CFG2  = 8'h42;  // D2.2

  typedef struct packed {
    logic       even;
    logic       is_k;
    logic [7:0] data;
  } rm_entry_t;

  typedef enum logic [1:0] {
    RD_FLUSH = 2'd0,
    RD_PRIME = 2'd1,
    RD_RUN   = 2'd2,
    RD_INS2  = 2'd3
  } rd_state_e;

endpackage

// File: rtl/rm_rst_sync.sv
module rm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/rm_ptr_sync.sv
// Two-flop synchronizer for a Gray-coded value, decoded to binary.
module rm_ptr_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ s2_q[i];
      bin_out[i] = acc;
    end
  end
endmodule

// File: rtl/rm_wr_ctrl.sv
module rm_wr_ctrl
  import gbe_rm_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_ok,
  input  logic [7:0]        in_byte,
  input  logic              in_k,
  input  logic [PTR_W-1:0]  rptr_bin,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output rm_entry_t         wentry,
  output logic [PTR_W-1:0]  wptr_gray,
  output logic              full
);
  logic [PTR_W-1:0] wptr_q, wptr_d, fill;
  logic             odd_q, odd_d;
  logic [PTR_W-1:0] gray_d;

  assign fill  = wptr_q - rptr_bin;
  assign full  = fill >= PTR_W'(DEPTH);
  assign we    = sync_ok && !full;
  assign waddr = wptr_q[ADDR_W-1:0];

  always_comb begin
    wentry.even = ~odd_q;
    wentry.is_k = in_k;
    wentry.data = in_byte;
  end

  always_comb begin
    wptr_d = wptr_q;
    odd_d  = odd_q;
    if (!sync_ok) begin
      wptr_d = '0;
      odd_d  = 1'b0;
    end else if (we) begin
      wptr_d = wptr_q + 1'b1;
      odd_d  = ~odd_q;
    end
    gray_d = wptr_d ^ (wptr_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      odd_q     <= 1'b0;
      wptr_gray <= '0;
    end else begin
      wptr_q    <= wptr_d;
      odd_q     <= odd_d;
      wptr_gray <= gray_d;
    end
  end
endmodule

// File: rtl/rm_rd_ctrl.sv
module rm_rd_ctrl
  import gbe_rm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int ADDR_W  = 5,
  parameter int PTR_W   = 6,
  parameter int HI_MARK = 24,
  parameter int LO_MARK = 8,
  parameter int PR_MARK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_ok,
  input  logic [PTR_W-1:0]  wptr_bin,
  input  rm_entry_t         head,
  input  rm_entry_t         nxt,
  output logic [ADDR_W-1:0] raddr0,
  output logic [ADDR_W-1:0] raddr1,
  output logic [PTR_W-1:0]  rptr_gray,
  output logic [PTR_W-1:0]  fill,
  output logic [7:0]        out_byte,
  output logic              out_k,
  output logic              out_valid,
  output logic              ins_pulse,
  output logic              del_pulse,
  output logic              empty
);
  rd_state_e        st_q, st_d;
  logic [PTR_W-1:0] rptr_q, rptr_d, raw, gray_d;
  logic             guard_q, guard_d;
  logic [7:0]       byte_d;
  logic             k_d, val_d, ins_d, del_d, empty_d;
  logic             head_comma, cand, stall;

  assign raddr0 = rptr_q[ADDR_W-1:0];
  assign raddr1 = raddr0 + 1'b1;
  assign raw    = wptr_bin - rptr_q;
  assign fill   = (raw > PTR_W'(DEPTH)) ? '0 : raw;

  assign head_comma = head.is_k && (head.data == SYM_COMMA);
  assign cand = head_comma && head.even && !nxt.is_k && (fill >= PTR_W'(2)) &&
                ((nxt.data == SYM_IDLE2) || (nxt.data == SYM_CFG2));
  assign stall = (fill == '0) || (head_comma && (fill < PTR_W'(2)));

  always_comb begin
    st_d    = st_q;
    rptr_d  = rptr_q;
    guard_d = guard_q;
    byte_d  = head.data;
    k_d     = head.is_k;
    val_d   = 1'b0;
    ins_d   = 1'b0;
    del_d   = 1'b0;
    empty_d = (fill == '0);
    if (!sync_ok) begin
      st_d    = RD_FLUSH;
      rptr_d  = '0;
      guard_d = 1'b0;
    end else begin
      unique case (st_q)
        RD_FLUSH: st_d = RD_PRIME;
        RD_PRIME: if (fill >= PTR_W'(PR_MARK)) st_d = RD_RUN;
        RD_RUN: begin
          if (!stall) begin
            if (cand && !guard_q && (fill > PTR_W'(HI_MARK))) begin
              rptr_d = rptr_q + PTR_W'(2);
              del_d  = 1'b1;
            end else if (cand && !guard_q && (fill < PTR_W'(LO_MARK))) begin
              val_d   = 1'b1;
              ins_d   = 1'b1;
              guard_d = 1'b1;
              st_d    = RD_INS2;
            end else begin
              val_d   = 1'b1;
              rptr_d  = rptr_q + 1'b1;
              guard_d = 1'b0;
            end
          end
        end
        RD_INS2: begin
          val_d  = 1'b1;
          byte_d = nxt.data;
          k_d    = nxt.is_k;
          st_d   = RD_RUN;
        end
        default: st_d = RD_FLUSH;
      endcase
    end
    gray_d = rptr_d ^ (rptr_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RD_FLUSH;
      rptr_q    <= '0;
      rptr_gray <= '0;
      guard_q   <= 1'b0;
      out_byte  <= '0;
      out_k     <= 1'b0;
      out_valid <= 1'b0;
      ins_pulse <= 1'b0;
      del_pulse <= 1'b0;
      empty     <= 1'b1;
    end else begin
      st_q      <= st_d;
      rptr_q    <= rptr_d;
      rptr_gray <= gray_d;
      guard_q   <= guard_d;
      out_byte  <= byte_d;
      out_k     <= k_d;
      out_valid <= val_d;
      ins_pulse <= ins_d;
      del_pulse <= del_d;
      empty     <= empty_d;
    end
  end
endmodule

// File: rtl/gbe_rate_matcher.sv
module gbe_rate_matcher
  import gbe_rm_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       wr_clk,
  input  logic       wr_rst_n,
  input  logic [7:0] wr_byte,
  input  logic       wr_is_k,
  input  logic       wr_sync_ok,
  output logic       wr_full,
  input  logic       rd_clk,
  input  logic       rd_rst_n,
  output logic [7:0] rd_byte,
  output logic       rd_is_k,
  output logic       rd_valid,
  output logic       rd_inserted,
  output logic       rd_deleted,
  output logic       rd_empty
);
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int PTR_W   = ADDR_W + 1;
  localparam int HI_MARK = (DEPTH * 3) / 4;
  localparam int LO_MARK = DEPTH / 4;
  localparam int PR_MARK = DEPTH / 2;

  logic              wr_rst_ns, rd_rst_ns;
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr0, raddr1;
  rm_entry_t         wentry, head, nxt;
  logic [PTR_W-1:0]  wptr_gray, rptr_gray, wptr_rd, rptr_wr, rd_fill;
  logic              rd_sync;

  rm_entry_t mem [DEPTH];

  rm_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_rst_n), .rst_n(wr_rst_ns));
  rm_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_rst_n), .rst_n(rd_rst_ns));

  rm_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_ns), .sync_ok(wr_sync_ok),
    .in_byte(wr_byte), .in_k(wr_is_k), .rptr_bin(rptr_wr),
    .we(we), .waddr(waddr), .wentry(wentry), .wptr_gray(wptr_gray),
    .full(wr_full)
  );

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign head = mem[raddr0];
  assign nxt  = mem[raddr1];

  rm_ptr_sync #(.W(PTR_W)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_ns), .gray_in(wptr_gray), .bin_out(wptr_rd)
  );
  rm_ptr_sync #(.W(PTR_W)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_ns), .gray_in(rptr_gray), .bin_out(rptr_wr)
  );
  rm_ptr_sync #(.W(1)) u_sync (
    .clk(rd_clk), .rst_n(rd_rst_ns), .gray_in(wr_sync_ok), .bin_out(rd_sync)
  );

  rm_rd_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
    .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .PR_MARK(PR_MARK)
  ) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_ns), .sync_ok(rd_sync), .wptr_bin(wptr_rd),
    .head(head), .nxt(nxt), .raddr0(raddr0), .raddr1(raddr1),
    .rptr_gray(rptr_gray), .fill(rd_fill),
    .out_byte(rd_byte), .out_k(rd_is_k), .out_valid(rd_valid),
    .ins_pulse(rd_inserted), .del_pulse(rd_deleted), .empty(rd_empty)
  );
endmodule

// File: rtl/gbe_rate_matcher_chk.sv
module gbe_rate_matcher_chk #(
  parameter int PTR_W   = 6,
  parameter int HI_MARK = 24,
  parameter int LO_MARK = 8
) (
  input logic             rd_clk,
  input logic             rd_rst_n,
  input logic [PTR_W-1:0] rd_fill,
  input logic             rd_sync,
  input logic             rd_valid,
  input logic [7:0]       rd_byte,
  input logic             rd_is_k,
  input logic             rd_inserted,
  input logic             rd_deleted,
  input logic             rd_empty
);
  // R4
  del_high_fill_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_deleted |-> ($past(rd_fill) > PTR_W'(HI_MARK)) && !rd_valid);

  // R5
  ins_low_fill_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_inserted |-> ($past(rd_fill) < PTR_W'(LO_MARK)) && rd_valid && rd_is_k &&
                    (rd_byte == 8'hBC));

  // R5
  ins_second_byte_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_inserted |=> rd_valid && !rd_inserted && !rd_deleted);

  // R2
  no_comp_unsynced_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_sync |=> !rd_inserted && !rd_deleted && !rd_valid);

  // R7
  single_action_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_inserted && rd_deleted));

  // R9
  empty_no_valid_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |-> !rd_valid);
endmodule

bind gbe_rate_matcher gbe_rate_matcher_chk #(
  .PTR_W(PTR_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
) u_chk (
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_fill(rd_fill), .rd_sync(rd_sync),
  .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_is_k(rd_is_k),
  .rd_inserted(rd_inserted), .rd_deleted(rd_deleted), .rd_empty(rd_empty)
);

// File: tb/tb_gbe_rate_matcher.sv
module tb_gbe_rate_matcher;
  timeunit 1ps;
  timeprecision 1ps;

  logic       wr_clk, rd_clk, wr_rst_n, rd_rst_n;
  logic [7:0] wr_byte;
  logic       wr_is_k, wr_sync_ok;
  logic       wr_full;
  logic [7:0] rd_byte;
  logic       rd_is_k, rd_valid, rd_inserted, rd_deleted, rd_empty;

  int wr_half = 4000;
  int n_chk = 0, n_fail = 0;
  int pos = 0;
  bit sb_off = 1'b1;
  bit ins_pend = 1'b0;
  int n_pop = 0, last_ins_pop = -1;
  int n_del = 0, n_ins = 0, n_c2 = 0, n_out = 0;
  int saw_empty = 0, saw_full = 0;
  logic [9:0] sb_q[$];

  gbe_rate_matcher dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_byte(wr_byte), .wr_is_k(wr_is_k),
    .wr_sync_ok(wr_sync_ok), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_byte(rd_byte), .rd_is_k(rd_is_k),
    .rd_valid(rd_valid), .rd_inserted(rd_inserted), .rd_deleted(rd_deleted),
    .rd_empty(rd_empty)
  );

  initial begin
    rd_clk = 1'b0;
    forever #4000 rd_clk = ~rd_clk;
  end
  initial begin
    wr_clk = 1'b0;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_cand(input logic [9:0] a, input logic [9:0] b);
    return a[9] && a[8] && (a[7:0] == 8'hBC) && !b[8] &&
           ((b[7:0] == 8'h50) || (b[7:0] == 8'h42));
  endfunction

  // Scoreboard monitor
  always @(negedge rd_clk) begin
    if (rd_valid) n_out++;
    if (rd_empty) saw_empty++;
    if (!sb_off) begin
      if (rd_deleted) begin
        n_del++;
        if (sb_q.size() >= 2) begin
          // R3 R6 R8: only a legal even-position candidate may vanish
          check(is_cand(sb_q[0], sb_q[1]), "R4 deleted unit not a candidate",
                {sb_q[0], sb_q[1][7:0]}, 32'hBC);
          check(!rd_valid, "R4 valid during deletion", rd_valid, 0);
          if (sb_q[1][7:0] == 8'h42) n_c2++;
          void'(sb_q.pop_front());
          void'(sb_q.pop_front());
          n_pop += 2;
        end else check(1'b0, "R4 deletion with short queue", sb_q.size(), 2);
      end else if (rd_inserted) begin
        n_ins++;
        if (sb_q.size() >= 2) begin
          check(is_cand(sb_q[0], sb_q[1]), "R5 inserted unit not a candidate",
                {sb_q[0], sb_q[1][7:0]}, 32'hBC);
          check({rd_is_k, rd_byte} == sb_q[0][8:0], "R5 first inserted byte",
                {rd_is_k, rd_byte}, sb_q[0][8:0]);
          check(n_pop != last_ins_pop, "R7 second insertion on one set",
                n_pop, last_ins_pop);
          if (sb_q[1][7:0] == 8'h42) n_c2++;
          last_ins_pop = n_pop;
          ins_pend = 1'b1;
        end else check(1'b0, "R5 insertion with short queue", sb_q.size(), 2);
      end else if (rd_valid) begin
        if (ins_pend) begin
          check({rd_is_k, rd_byte} == sb_q[1][8:0], "R5 second inserted byte",
                {rd_is_k, rd_byte}, sb_q[1][8:0]);
          ins_pend = 1'b0;
        end else if (sb_q.size() == 0) begin
          check(1'b0, "R1 output with empty queue", {rd_is_k, rd_byte}, 0);
        end else begin
          check({rd_is_k, rd_byte} == sb_q[0][8:0], "R1 byte order/flag",
                {rd_is_k, rd_byte}, sb_q[0][8:0]);
          void'(sb_q.pop_front());
          n_pop++;
        end
      end
    end
  end

  always @(negedge wr_clk) if (wr_full) saw_full++;

  // Driver: one byte per write clock
  task automatic send(input bit k, input logic [7:0] d, input bit s);
    @(negedge wr_clk);
    wr_is_k    = k;
    wr_byte    = d;
    wr_sync_ok = s;
    if (s) begin
      if (!sb_off) sb_q.push_back({~pos[0], k, d});
      pos++;
    end else pos = 0;
  endtask

  task automatic traffic(input int nblk, input bit with_c2);
    for (int b = 0; b < nblk; b++) begin
      for (int i = 0; i < 20; i++) send(1'b0, 8'((b * 7 + i) & 8'h7F), 1'b1);
      send(1'b1, 8'hBC, 1'b1); send(1'b0, 8'hC5, 1'b1);  // D5.6 idle
      for (int i = 0; i < 3; i++) begin
        send(1'b1, 8'hBC, 1'b1); send(1'b0, 8'h50, 1'b1);
      end
      if (b % 3 == 0) begin  // odd-position decoy (R8)
        send(1'b0, 8'h11, 1'b1);
        send(1'b1, 8'hBC, 1'b1); send(1'b0, 8'h50, 1'b1);
        send(1'b0, 8'h22, 1'b1);
      end
      if (with_c2 && (b % 2 == 1)) begin
        for (int i = 0; i < 2; i++) begin
          send(1'b1, 8'hBC, 1'b1); send(1'b0, 8'h42, 1'b1);
          send(1'b0, 8'hA0, 1'b1); send(1'b0, 8'h01, 1'b1);
        end
      end
    end
  endtask

  task automatic data_run(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 8'(i & 8'h7F), 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge rd_clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int out0, del0, ins0;
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_byte = 8'h00; wr_is_k = 1'b0; wr_sync_ok = 1'b0;
    repeat (10) @(posedge rd_clk);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    // R10
    check(!rd_valid, "R10 valid after reset", rd_valid, 0);
    check(rd_empty, "R10 empty after reset", rd_empty, 1);
    check(!wr_full, "R10 full after reset", wr_full, 0);
    check(!rd_inserted && !rd_deleted, "R10 pulses after reset",
          {rd_inserted, rd_deleted}, 0);

    // R2: unsynchronized stream produces nothing
    out0 = n_out;
    for (int i = 0; i < 100; i++) begin
      send(1'b1, 8'hBC, 1'b0); send(1'b0, 8'h50, 1'b0);
    end
    check(n_out == out0, "R2 output while unsynchronized", n_out - out0, 0);

    // R1: equal clocks
    sb_off = 1'b0;
    traffic(15, 1'b1);

    // R4: write side faster
    del0 = n_del;
    wr_half = 3900;
    traffic(80, 1'b1);
    check(n_del > del0, "R4 no deletion at high fill", n_del - del0, 1);

    // R5: write side slower
    ins0 = n_ins;
    wr_half = 4100;
    traffic(80, 1'b1);
    check(n_ins > ins0, "R5 no insertion at low fill", n_ins - ins0, 1);
    check(n_c2 > 0, "R6 configuration unit never compensated", n_c2, 1);

    // R9: drain to empty
    saw_empty = 0;
    data_run(1500);
    check(saw_empty > 0, "R9 empty never reported", saw_empty, 1);

    // R9: fill to full, scoreboard off since writes are dropped
    sb_off = 1'b1;
    saw_full = 0;
    wr_half = 3900;
    data_run(3000);
    check(saw_full > 0, "R9 full never reported", saw_full, 1);

    // R2: flush on loss of sync
    wr_half = 4000;
    for (int i = 0; i < 60; i++) send(1'b1, 8'hBC, 1'b0);
    repeat (4) @(negedge rd_clk);
    check(rd_empty && !rd_valid, "R2 buffer not flushed", {rd_empty, rd_valid}, 2);
    check(!wr_full, "R2 full after flush", wr_full, 0);
    sb_q.delete();
    ins_pend = 1'b0;
    last_ins_pop = -1;
    out0 = n_out;
    sb_off = 1'b0;
    traffic(10, 1'b0);
    sb_off = 1'b1;
    check(n_out > out0, "R2 no output after resync", n_out - out0, 1);

    finish_run();
  end
endmodule